// File: doc/BRIEF.md
# Sync-Word Triggered Receive Bit FIFO

This block sits behind a receiver's bit slicer. Every received bit comes with a valid strobe and a valid-data indicator. A start condition decides whether each bit is kept. Kept bits go into a bit-wide FIFO, 64 entries deep. A host drains the FIFO one bit at a time through a pop strobe. The oldest stored bit is always shown on a single read output.

The block is set up by 16-bit command words. A word is accepted only when its upper byte is 0xCE. The low byte holds four fields:
- the interrupt level;
- the start-condition selector;
- a fill-enable bit;
- a FIFO-enable bit.

There are three start conditions:
- gate each bit with the valid-data indicator;
- keep every bit;
- hunt for the fixed 16-bit pattern 0x2DD4 and keep everything after it.

Turning the fill-enable bit off and then on again empties the FIFO and re-arms the hunt. The interrupt output tells the host that enough bits are waiting.

Top module: `sync_rx_fifo`

## Requirements
- R1: After reset, the low byte of the configuration is 0x87. This means interrupt level 8, selector 01, fill enabled and FIFO enabled. The fill count is 0, the interrupt is low and the read bit is 0.
- R2: A command write takes effect only when cmd_data[15:8] equals 0xCE. Any other write changes nothing.
- R3: The low-byte fields are: bits 7..4 interrupt level, bits 3..2 selector, bit 1 fill enable, bit 0 FIFO enable. With selector 00, or 01 (reserved, acts as 00), a valid bit is stored only when vdi_in is high in the same cycle.
- R4: With selector 11, every valid bit is stored.
- R5: With selector 10, valid bits shift into a 16-bit register, newest bit in the LSB. The first bit that completes the value 0x2DD4 arms capture. Only bits after that one are stored; the pattern bits are not.
- R6: While fill enable is 0, nothing is stored and the sync hunt is held in its reset state. Bits already stored stay readable.
- R7: A write that sets fill enable while it was 0 empties the FIFO and restarts the sync hunt.
- R8: While FIFO enable is 0, the FIFO is empty and nothing is stored. Writing it to 0 clears the count on that edge.
- R9: When 64 bits are held, further incoming bits are dropped and the count stays at 64. The exception is a cycle that also pops: then the new bit is stored.
- R10: rd_bit shows the oldest stored bit, or 0 when the FIFO is empty. A pop removes that bit. A pop on an empty FIFO does nothing. A push and a pop in the same cycle leave the count unchanged.
- R11: irq is high exactly when the count is nonzero and at least the interrupt level. It drops as soon as pops take the count below the level.
- R12: fill_count gives the number of stored bits. It updates on the clock edge that samples the push, pop or command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word (prefix in upper byte) |
| bit_valid | input | 1 | Received bit strobe |
| bit_data | input | 1 | Received bit value |
| vdi_in | input | 1 | Valid-data indicator from the receiver |
| rd_pop | input | 1 | Remove the oldest stored bit |
| rd_bit | output | 1 | Oldest stored bit |
| fill_count | output | 7 | Number of stored bits |
| irq | output | 1 | Fill level reached |

## Verification
The bench aims at the sync hunt:
- It sends a run of zeros, then the exact pattern, then payload. A design that stores the pattern bits, or arms one bit late, reports the wrong count and the wrong head bit.
- It fills the FIFO past 64 bits. A design that wraps or overflows shows a count that drops or goes past 64.
- It pushes and pops in the same cycle while the FIFO is partly full. A design that lets one of the two win changes the count.
- It toggles fill enable and FIFO enable. A design that misses the flush keeps stale bits.
- It drains the FIFO across the interrupt threshold. A design using a strict compare fires one bit late.

Random traffic and random commands then run against a queue model kept in the bench.

// File: rtl/sync_rx_pkg.sv
// Shared constants and types for the sync-triggered receive bit FIFO.
// Assumes the command format: 8-bit prefix above an 8-bit field byte.
package sync_rx_pkg;
    localparam logic [7:0]  CMD_PREFIX = 8'hCE;
    localparam logic [7:0]  CFG_RESET  = 8'h87;
    localparam int          SYNC_W     = 16;
    localparam logic [15:0] SYNC_PAT   = 16'h2DD4;

    typedef enum logic [1:0] {
        START_VDI    = 2'b00,
        START_RSVD   = 2'b01,
        START_SYNC   = 2'b10,
        START_ALWAYS = 2'b11
    } start_sel_e;

    typedef struct packed {
        logic [3:0] level;
        start_sel_e sel;
        logic       fill_en;
        logic       fifo_en;
    } rx_cfg_t;
endpackage

// File: rtl/sync_rx_cfg.sv
// Command register: takes a word whose upper byte matches the prefix.
// It also flags a flush when fill enable rises or FIFO enable is written 0.
// Assumes cmd_wr is a single-cycle strobe; the flag is combinational.
module sync_rx_cfg
    import sync_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [15:0]   cmd_data,
    output rx_cfg_t       cfg,
    output logic          flush_req
);
    logic    hit;
    rx_cfg_t nxt;

    // Decode a write and the configuration it would load.
    always_comb begin
        hit       = cmd_wr && (cmd_data[15:8] == CMD_PREFIX);
        nxt       = rx_cfg_t'(cmd_data[7:0]);
        flush_req = hit && ((nxt.fill_en && !cfg.fill_en) || !nxt.fifo_en);
    end

    // Hold the field byte; load it on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)   cfg <= rx_cfg_t'(CFG_RESET);
        else if (hit) cfg <= nxt;
    end
endmodule

// File: rtl/sync_rx_detect.sv
// Sync-pattern hunter: shifts valid bits MSB-first and arms when the
// shift register, including the incoming bit, equals PATTERN.
// Stays armed until cleared. The bit that completes the match is not
// counted as payload, because armed rises only after that edge.
module sync_rx_detect #(
    parameter int              WIDTH   = 16,
    parameter logic [WIDTH-1:0] PATTERN = 16'h2DD4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic shift_en,
    input  logic bit_in,
    output logic armed
);
    logic [WIDTH-1:0] shreg;
    logic [WIDTH-1:0] shnext;

    // Next shift value with the incoming bit as LSB.
    always_comb shnext = {shreg[WIDTH-2:0], bit_in};

    // Shift while hunting, arm on a match, reset on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg <= '0;
            armed <= 1'b0;
        end else if (shift_en && !armed) begin
            shreg <= shnext;
            if (shnext == PATTERN) armed <= 1'b1;
        end
    end
endmodule

// File: rtl/sync_rx_bitfifo.sv
// One-bit-wide circular FIFO with a registered count.
// Assumes DEPTH is a power of two, so the pointers wrap by themselves.
// clr overrides push and pop. A push while full is taken only if a pop
// frees a slot in the same cycle.
module sync_rx_bitfifo #(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             push_bit,
    input  logic             pop,
    output logic             head_bit,
    output logic [CNT_W-1:0] count
);
    logic [DEPTH-1:0] mem;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_pop;
    logic             do_push;

    // Qualify the strobes against the occupancy.
    always_comb begin
        do_pop   = pop && (count != '0);
        do_push  = push && ((count != CNT_W'(DEPTH)) || do_pop);
        head_bit = (count != '0) ? mem[rd_ptr] : 1'b0;
    end

    // Advance the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // Write the stored bit; the storage needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_bit;
    end
endmodule

// File: rtl/sync_rx_fifo.sv
// Top: joins the command register, the sync hunter and the bit FIFO.
// Picks the start condition and drives the level interrupt.
// Assumes bit_valid is high for one cycle per received bit.
module sync_rx_fifo
    import sync_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [15:0]      cmd_data,
    input  logic             bit_valid,
    input  logic             bit_data,
    input  logic             vdi_in,
    input  logic             rd_pop,
    output logic             rd_bit,
    output logic [CNT_W-1:0] fill_count,
    output logic             irq
);
    rx_cfg_t cfg;
    logic    flush_req;
    logic    armed;
    logic    start_ok;
    logic    capture_on;
    logic    push;
    logic    fifo_clr;
    logic    hunt_clr;
    logic    hunt_shift;

    sync_rx_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_data (cmd_data),
        .cfg      (cfg),
        .flush_req(flush_req)
    );

    // Choose the start condition and gate pushes and hunting.
    always_comb begin
        unique case (cfg.sel)
            START_SYNC:   start_ok = armed;
            START_ALWAYS: start_ok = 1'b1;
            default:      start_ok = vdi_in;
        endcase
        capture_on = cfg.fifo_en && cfg.fill_en;
        push       = bit_valid && capture_on && start_ok;
        fifo_clr   = flush_req || !cfg.fifo_en;
        hunt_clr   = flush_req || !capture_on;
        hunt_shift = bit_valid && capture_on && (cfg.sel == START_SYNC);
    end

    sync_rx_detect #(.WIDTH(SYNC_W), .PATTERN(SYNC_PAT)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hunt_clr),
        .shift_en(hunt_shift),
        .bit_in  (bit_data),
        .armed   (armed)
    );

    sync_rx_bitfifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fifo_clr),
        .push    (push),
        .push_bit(bit_data),
        .pop     (rd_pop),
        .head_bit(rd_bit),
        .count   (fill_count)
    );

    // Interrupt when the count is nonzero and has reached the level.
    always_comb irq = (fill_count != '0) && (fill_count >= CNT_W'(cfg.level));
endmodule

// File: rtl/sync_rx_fifo_chk.sv
// Checker for sync_rx_fifo, looking at its ports only; bound below.
module sync_rx_fifo_chk #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic             bit_valid,
    input logic             rd_pop,
    input logic [CNT_W-1:0] fill_count,
    input logic             irq
);
    // R9
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == CNT_W'(DEPTH) && !rd_pop)
        |=> (fill_count == CNT_W'(DEPTH) || fill_count == '0));

    // R12
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count > $past(fill_count)) |-> (fill_count == $past(fill_count) + 1'b1));

    // R10
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && fill_count != '0 && !bit_valid && !cmd_wr)
        |=> (fill_count == $past(fill_count) - 1'b1));

    // R12
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_pop && !bit_valid && !cmd_wr) |=> $stable(fill_count));

    // R11
    irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fill_count != '0));
endmodule

bind sync_rx_fifo sync_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .bit_valid (bit_valid),
    .rd_pop    (rd_pop),
    .fill_count(fill_count),
    .irq       (irq)
);

// File: tb/sync_rx_fifo_test.sv
// Bench: directed corner cases, then seeded random traffic, all
// compared against a queue model written from the requirements.
module sync_rx_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        bit_valid = 1'b0;
    logic        bit_data = 1'b0;
    logic        vdi_in = 1'b0;
    logic        rd_pop = 1'b0;
    logic        rd_bit;
    logic [6:0]  fill_count;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // Model state
    bit        mq[$];
    bit [7:0]  m_cfg;
    bit [15:0] m_sh;
    bit        m_armed;

    sync_rx_fifo uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .bit_valid(bit_valid), .bit_data(bit_data), .vdi_in(vdi_in),
        .rd_pop(rd_pop), .rd_bit(rd_bit), .fill_count(fill_count), .irq(irq)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit m_head();
        return (mq.size() != 0) ? mq[0] : 1'b0;
    endfunction

    function automatic bit m_irq();
        return (mq.size() != 0) && (mq.size() >= int'(m_cfg[7:4]));
    endfunction

    // One clock: apply inputs, update the model at the edge, compare.
    task automatic step(input bit wr, input bit [15:0] d, input bit bv,
                        input bit bd, input bit vdi, input bit pop);
        bit hit, flush, cap, ok, push, dopop;
        bit [15:0] nsh;
        cmd_wr = wr; cmd_data = d; bit_valid = bv; bit_data = bd;
        vdi_in = vdi; rd_pop = pop;
        hit   = wr && d[15:8] == 8'hCE;
        flush = (hit && ((d[1] && !m_cfg[1]) || !d[0])) || !m_cfg[0];
        cap   = m_cfg[0] && m_cfg[1];
        case (m_cfg[3:2])
            2'b10:   ok = m_armed;
            2'b11:   ok = 1'b1;
            default: ok = vdi;
        endcase
        push  = bv && cap && ok;
        dopop = pop && mq.size() != 0;
        @(posedge clk);
        if (flush) mq.delete();
        else begin
            if (dopop) void'(mq.pop_front());
            if (push && mq.size() < 64) mq.push_back(bd);
        end
        if (flush || !cap) begin
            m_sh = '0; m_armed = 0;
        end else if (bv && m_cfg[3:2] == 2'b10 && !m_armed) begin
            nsh = {m_sh[14:0], bd};
            m_sh = nsh;
            if (nsh == 16'h2DD4) m_armed = 1;
        end
        if (hit) m_cfg = d[7:0];
        #2;
        chk("R12 count", int'(fill_count), mq.size());
        chk("R11 irq", int'(irq), int'(m_irq()));
        chk("R10 head", int'(rd_bit), int'(m_head()));
        @(negedge clk);
        cmd_wr = 0; bit_valid = 0; rd_pop = 0;
    endtask

    task automatic cmd(input bit [15:0] w);
        step(1, w, 0, 0, 0, 0);
    endtask

    task automatic send(input bit b, input bit vdi);
        step(0, 16'h0, 1, b, vdi, 0);
    endtask

    task automatic pop1();
        step(0, 16'h0, 0, 0, 0, 1);
    endtask

    initial begin
        bit [15:0] pat;
        void'($urandom(32'h5EED_0042));
        m_cfg = 8'h87; m_sh = '0; m_armed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk("R1 count", int'(fill_count), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 rd_bit", int'(rd_bit), 0);
        @(negedge clk);

        // R3: the default selector gates bits with vdi_in
        send(1, 1);
        chk("R3 stored with vdi", int'(fill_count), 1);
        send(0, 0);
        chk("R3 dropped without vdi", int'(fill_count), 1);

        // R2: a wrong prefix changes nothing, so VDI gating stays
        cmd(16'h12FF);
        send(0, 0);
        chk("R2 bad prefix ignored", int'(fill_count), 1);

        // R6: fill disabled; the stored bit stays readable
        cmd(16'hCE4D);
        send(0, 1);
        chk("R6 no store", int'(fill_count), 1);
        chk("R6 bit kept", int'(rd_bit), 1);

        // R7: re-enabling fill flushes
        cmd(16'hCE4F);
        chk("R7 flushed", int'(fill_count), 0);

        // R4 and R9: always-fill mode, overfill past 64
        for (int i = 0; i < 70; i++) send(i[0], 0);
        chk("R4 R9 saturate", int'(fill_count), 64);
        chk("R11 irq full", int'(irq), 1);

        // R11: drain to 3, which is below level 4
        for (int i = 0; i < 61; i++) pop1();
        chk("R11 below level", int'(irq), 0);
        chk("R10 drained", int'(fill_count), 3);

        // R8: FIFO disable clears the count and blocks stores
        cmd(16'hCE4E);
        chk("R8 cleared", int'(fill_count), 0);
        send(1, 1);
        chk("R8 no store", int'(fill_count), 0);

        // R5: sync mode; zeros, then the pattern, then 5 payload bits
        cmd(16'hCE4B);
        for (int i = 0; i < 8; i++) send(0, 1);
        pat = 16'h2DD4;
        for (int i = 15; i >= 0; i--) send(pat[i], 1);
        chk("R5 pattern not stored", int'(fill_count), 0);
        send(1, 0); send(0, 0); send(1, 0); send(1, 0); send(0, 0);
        chk("R5 payload count", int'(fill_count), 5);
        chk("R5 head is first payload bit", int'(rd_bit), 1);

        // R10: push and pop in the same cycle keep the count
        step(0, 16'h0, 1, 1, 0, 1);
        chk("R10 push+pop count", int'(fill_count), 5);
        chk("R10 next head", int'(rd_bit), 0);
        for (int i = 0; i < 7; i++) pop1();
        chk("R10 pop on empty", int'(fill_count), 0);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit wr;
            bit [15:0] d;
            wr = ($urandom % 40) == 0;
            d[15:8] = (($urandom % 4) != 0) ? 8'hCE : 8'($urandom);
            d[7:0]  = 8'($urandom);
            if (($urandom % 4) != 0) d[1:0] = 2'b11;
            step(wr, d, ($urandom % 2) == 1, ($urandom % 2) == 1,
                 ($urandom % 10) < 7, ($urandom % 10) < 3);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule